// File: doc/BRIEF.md
# Slot-Based Reconfiguration Broadcast Scheduler

Each router in an on-chip mesh carries one copy of this controller. When a link fault changes the topology, every router must announce in turn how it can be reached, and these announcements must never overlap. No arbiter and no handshake are used. Instead, every copy runs an identical cycle counter that is cleared by the common reset, so all routers agree on the time. The counter is read as two fields. The upper field names the node whose broadcast slot is active. The lower field counts cycles inside that slot.

A router that detects a fault arms itself and waits for its own slot. In that slot it injects the first broadcast and becomes the root. Every other router notices the incoming flag and joins. The joining router takes the current slot owner as the root. From the slot after the root's, each node strobes its own one-bit flag once, at the start of its own slot. After the slot just before the root's has run out, the controller pulses a done signal. If two detectors compete, the one that hears a broadcast before its own slot arrives resigns, so only one reconfiguration takes place. A fault seen while a reconfiguration is running is remembered and re-arms the node as soon as the current run finishes.

Top module: `recfg_bcast_sched`

## Requirements
- R1: `slot_owner_o` is bits [7:4] of an 8-bit cycle counter that reset clears and that advances by one every clock (defaults NODES=16, SLOT_CYC=16). Bits [3:0] are the in-slot offset, so the owner steps by one, modulo 16, every 16 cycles.
- R2: While reset is held and after it is released, with no stimulus, `inj_o`, `first_o` and `done_o` are low.
- R3: A fault pulse while the node is idle arms it. At the next cycle where the owner equals `node_id_i` and the offset is 0, `inj_o` is high for that one cycle and the node becomes the root.
- R4: `first_o` is high on every cycle of the root's slot during which this node is armed at the root's injection or is running a reconfiguration. It is low in every other slot.
- R5: A running node that is not the root raises `inj_o` exactly once, at offset 0 of its own slot. The root never injects again during the same reconfiguration.
- R6: An idle node that sees any `flag_i` bit high joins the reconfiguration on the next cycle. The root it records is the owner at that moment.
- R7: An armed detector that sees a flag in another node's slot resigns. It runs a reconfiguration rooted at that slot's owner, and it still broadcasts once in its own later slot.
- R8: `done_o` is a one-cycle pulse. It appears on the cycle after the offset reaches 15 in the slot whose owner is root−1 modulo 16. That is 256 cycles after the root's slot began.
- R9: A fault pulse that arrives while a reconfiguration runs does not change it. The pulse is remembered. On the cycle of `done_o` the node is armed again, and it injects at once if that cycle begins its own slot.
- R10: Flag inputs have no effect while a reconfiguration runs: the done timing and the injection slots stay unchanged.
- R11: An armed node at offset 0 of its own slot injects as root even if a flag is high in that same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock shared by all routers |
| rst_ni | input | 1 | Asynchronous reset, active low, common to all routers |
| node_id_i | input | 4 | Static unique identifier of this router |
| fault_i | input | 1 | Local fault-detect pulse |
| flag_i | input | 4 | Incoming broadcast flag lines, one per neighbour port |
| inj_o | output | 1 | Strobe: inject this node's broadcast flag now |
| slot_owner_o | output | 4 | Node whose broadcast slot is active |
| first_o | output | 1 | High during the root's slot (first broadcast) |
| done_o | output | 1 | One-cycle pulse at the end of the reconfiguration |

## Verification
The bench builds the block with its defaults: 16 nodes, 16-cycle slots and four flag ports. This gives a 256-cycle sweep, short enough that a single run covers several back-to-back reconfigurations and the counter wrap from owner 15 to owner 0. Directed cases cover these situations: a root whose last slot lies in the next counter round, a resigning detector, a joiner whose root is node 15, and a latched fault that re-arms exactly at the start of the root's own slot. Random node IDs, fault pulses and flag patterns are then compared cycle by cycle against a model computed in the bench.

// File: rtl/recfg_pkg.sv
package recfg_pkg;

   typedef enum logic [1:0] {
      ST_IDLE  = 2'd0,
      ST_ARMED = 2'd1,
      ST_RUN   = 2'd2
   } rc_state_e;

endpackage

// File: rtl/recfg_slot_timer.sv
module recfg_slot_timer #(
   parameter int unsigned NODES    = 16,
   parameter int unsigned SLOT_CYC = 16,
   localparam int unsigned ID_W    = $clog2(NODES)
) (
   input  logic            clk_i,
   input  logic            rst_ni,
   output logic [ID_W-1:0] owner_o,
   output logic            slot_start_o,
   output logic            slot_end_o
);
   localparam int unsigned OFF_W = $clog2(SLOT_CYC);
   localparam int unsigned CW    = ID_W + OFF_W;

   if (NODES < 2 || (1 << ID_W) != NODES) begin : g_bad_nodes
      $error("NODES must be a power of two of at least 2");
   end
   if (SLOT_CYC < 2 || (1 << OFF_W) != SLOT_CYC) begin : g_bad_slot
      $error("SLOT_CYC must be a power of two of at least 2");
   end

   logic [CW-1:0]    cnt_q;
   logic [OFF_W-1:0] off;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) cnt_q <= '0;
      else         cnt_q <= cnt_q + 1'b1;
   end

   assign owner_o      = cnt_q[CW-1 -: ID_W];
   assign off          = cnt_q[OFF_W-1:0];
   assign slot_start_o = (off == '0);
   assign slot_end_o   = (&off);

   // R1: owner advances exactly at a slot boundary
   a_r1_owner_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
      slot_end_o |=> (owner_o == ID_W'($past(owner_o) + 1'b1)));
   a_r1_owner_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !slot_end_o |=> $stable(owner_o));
endmodule

// File: rtl/recfg_flag_merge.sv
module recfg_flag_merge #(
   parameter int unsigned PORTS = 4
) (
   input  logic [PORTS-1:0] flag_i,
   output logic             any_o
);
   if (PORTS < 1) begin : g_bad_ports
      $error("PORTS must be at least 1");
   end

   if (PORTS == 1) begin : g_single
      assign any_o = flag_i[0];
   end else begin : g_multi
      assign any_o = |flag_i;
   end
endmodule

// File: rtl/recfg_fsm.sv
module recfg_fsm
   import recfg_pkg::*;
#(
   parameter int unsigned NODES = 16,
   localparam int unsigned ID_W = $clog2(NODES)
) (
   input  logic            clk_i,
   input  logic            rst_ni,
   input  logic [ID_W-1:0] my_id_i,
   input  logic [ID_W-1:0] owner_i,
   input  logic            slot_start_i,
   input  logic            slot_end_i,
   input  logic            fault_i,
   input  logic            flag_any_i,
   output logic            inj_o,
   output logic            first_o,
   output logic            done_o
);
   rc_state_e       st_q, st_d;
   logic [ID_W-1:0] root_q, root_d;
   logic            latch_q, latch_d;
   logic            done_q, done_d;
   logic [ID_W-1:0] last_owner;
   logic            own_start;
   logic            run_end;

   assign last_owner = ID_W'(root_q - 1'b1);
   assign own_start  = slot_start_i && (owner_i == my_id_i);
   assign run_end    = (st_q == ST_RUN) && slot_end_i && (owner_i == last_owner);

   always_comb begin
      st_d    = st_q;
      root_d  = root_q;
      latch_d = latch_q;
      done_d  = 1'b0;
      unique case (st_q)
         ST_IDLE: begin
            if (flag_any_i) begin
               st_d    = ST_RUN;
               root_d  = owner_i;
               latch_d = fault_i;
            end else if (fault_i) begin
               st_d = ST_ARMED;
            end
         end
         ST_ARMED: begin
            if (own_start) begin
               st_d   = ST_RUN;
               root_d = my_id_i;
            end else if (flag_any_i) begin
               st_d   = ST_RUN;
               root_d = owner_i;
            end
         end
         ST_RUN: begin
            if (run_end) begin
               done_d  = 1'b1;
               latch_d = 1'b0;
               st_d    = (latch_q || fault_i) ? ST_ARMED : ST_IDLE;
            end else if (fault_i) begin
               latch_d = 1'b1;
            end
         end
         default: st_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         st_q    <= ST_IDLE;
         root_q  <= '0;
         latch_q <= 1'b0;
         done_q  <= 1'b0;
      end else begin
         st_q    <= st_d;
         root_q  <= root_d;
         latch_q <= latch_d;
         done_q  <= done_d;
      end
   end

   assign inj_o   = ((st_q == ST_ARMED) && own_start) ||
                    ((st_q == ST_RUN) && own_start && (root_q != my_id_i));
   assign first_o = ((st_q == ST_ARMED) && own_start) ||
                    ((st_q == ST_RUN) && (owner_i == root_q));
   assign done_o  = done_q;

   // R3 / R5: strobes only at the start of this node's own slot
   a_r3_inj_own_slot: assert property (@(posedge clk_i) disable iff (!rst_ni)
      inj_o |-> (slot_start_i && owner_i == my_id_i));
   // R8: done is a single-cycle pulse following the slot before the root's
   a_r8_done_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
      done_o |=> !done_o);
   a_r8_done_after_last: assert property (@(posedge clk_i) disable iff (!rst_ni)
      done_o |-> ($past(slot_end_i) && $past(owner_i) == ID_W'($past(root_q) - 1'b1)));
   // R6: idle node joins with the current owner as root
   a_r6_join_root: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (st_q == ST_IDLE && flag_any_i) |=> (st_q == ST_RUN && root_q == $past(owner_i)));
   // R9 / R10: a running reconfiguration is left only at its last slot
   a_r9_run_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (st_q == ST_RUN && !run_end) |=> (st_q == ST_RUN && $stable(root_q)));
   // R11: armed node at its own slot start always becomes root
   a_r11_own_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (st_q == ST_ARMED && own_start) |=> (st_q == ST_RUN && root_q == my_id_i));
endmodule

// File: rtl/recfg_bcast_sched.sv
module recfg_bcast_sched #(
   parameter int unsigned NODES    = 16,
   parameter int unsigned SLOT_CYC = 16,
   parameter int unsigned PORTS    = 4,
   localparam int unsigned ID_W    = $clog2(NODES)
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic [ID_W-1:0]  node_id_i,
   input  logic             fault_i,
   input  logic [PORTS-1:0] flag_i,
   output logic             inj_o,
   output logic [ID_W-1:0]  slot_owner_o,
   output logic             first_o,
   output logic             done_o
);
   logic            slot_start;
   logic            slot_end;
   logic            flag_any;
   logic [ID_W-1:0] owner;

   recfg_slot_timer #(.NODES(NODES), .SLOT_CYC(SLOT_CYC)) timer_i (
      .clk_i        (clk_i),
      .rst_ni       (rst_ni),
      .owner_o      (owner),
      .slot_start_o (slot_start),
      .slot_end_o   (slot_end)
   );

   recfg_flag_merge #(.PORTS(PORTS)) merge_i (
      .flag_i (flag_i),
      .any_o  (flag_any)
   );

   recfg_fsm #(.NODES(NODES)) fsm_i (
      .clk_i        (clk_i),
      .rst_ni       (rst_ni),
      .my_id_i      (node_id_i),
      .owner_i      (owner),
      .slot_start_i (slot_start),
      .slot_end_i   (slot_end),
      .fault_i      (fault_i),
      .flag_any_i   (flag_any),
      .inj_o        (inj_o),
      .first_o      (first_o),
      .done_o       (done_o)
   );

   assign slot_owner_o = owner;

   // R2: no strobe or pulse while reset is asserted
   a_r2_quiet_in_reset: assert property (@(posedge clk_i)
      !rst_ni |-> (!inj_o && !done_o));
endmodule

// File: tb/recfg_bcast_sched_tb_top.sv
module recfg_bcast_sched_tb_top;
   localparam int N  = 16;
   localparam int S  = 16;
   localparam int P  = 4;
   localparam int IW = 4;

   logic          clk = 1'b0;
   logic          rst_ni = 1'b0;
   logic [IW-1:0] node_id = '0;
   logic          fault = 1'b0;
   logic [P-1:0]  flags = '0;
   logic          inj, first, done;
   logic [IW-1:0] owner;

   int tcyc = 0;
   int n_chk = 0;
   int n_err = 0;
   bit finished = 1'b0;

   always #4 clk = ~clk;

   recfg_bcast_sched #(.NODES(N), .SLOT_CYC(S), .PORTS(P)) dut_i (
      .clk_i        (clk),
      .rst_ni       (rst_ni),
      .node_id_i    (node_id),
      .fault_i      (fault),
      .flag_i       (flags),
      .inj_o        (inj),
      .slot_owner_o (owner),
      .first_o      (first),
      .done_o       (done)
   );

   always @(posedge clk) begin
      if (!rst_ni) tcyc <= 0;
      else         tcyc <= tcyc + 1;
   end

   // ---------------- reference model from the requirements ----------------
   int m_st = 0;      // 0 idle, 1 armed, 2 running
   int m_root = 0;
   bit m_latch = 0;
   bit m_done = 0;

   function automatic int own_of(int t);
      return (t / S) % N;
   endfunction
   function automatic int off_of(int t);
      return t % S;
   endfunction
   function automatic bit m_own_start(int t);
      return (off_of(t) == 0) && (own_of(t) == int'(node_id));
   endfunction
   function automatic bit m_inj(int t);
      return (m_st == 1 && m_own_start(t)) ||
             (m_st == 2 && m_own_start(t) && m_root != int'(node_id));
   endfunction
   function automatic bit m_first(int t);
      return (m_st == 1 && m_own_start(t)) || (m_st == 2 && own_of(t) == m_root);
   endfunction

   always @(posedge clk) begin
      if (!rst_ni) begin
         m_st <= 0; m_root <= 0; m_latch <= 0; m_done <= 0;
      end else begin
         m_done <= 0;
         if (m_st == 0) begin
            if (|flags) begin
               m_st <= 2; m_root <= own_of(tcyc); m_latch <= fault;
            end else if (fault) m_st <= 1;
         end else if (m_st == 1) begin
            if (m_own_start(tcyc)) begin
               m_st <= 2; m_root <= int'(node_id);
            end else if (|flags) begin
               m_st <= 2; m_root <= own_of(tcyc);
            end
         end else begin
            if (off_of(tcyc) == S - 1 && own_of(tcyc) == (m_root + N - 1) % N) begin
               m_done <= 1; m_latch <= 0;
               m_st <= (m_latch || fault) ? 1 : 0;
            end else if (fault) m_latch <= 1;
         end
      end
   end

   // ---------------- helpers ----------------
   task automatic check(string req, int act, int exp);
      n_chk++;
      if (act != exp) begin
         n_err++;
         $display("FAIL %s at cycle %0d: actual=%0d expected=%0d", req, tcyc, act, exp);
      end
   endtask

   task automatic run_to(int t);
      while (tcyc < t) begin
         @(negedge clk);
         fault = 1'b0;
         flags = '0;
      end
   endtask

   task automatic do_reset(int id);
      @(negedge clk);
      rst_ni  = 1'b0;
      node_id = IW'(id);
      fault   = 1'b0;
      flags   = '0;
      repeat (3) @(negedge clk);
      check("R2 inj in reset", int'(inj), 0);
      check("R2 done in reset", int'(done), 0);
      rst_ni = 1'b1;
   endtask

   int inj_cnt;

   initial begin
      // ---- reset state and counter fields
      do_reset(5);
      check("R2 first after reset", int'(first), 0);
      check("R1 owner after reset", int'(owner), 0);
      run_to(37);
      check("R1 owner at cycle 37", int'(owner), own_of(37));

      // ---- Scenario A: root detector, latched fault, ignored flags
      run_to(10); fault = 1'b1;
      inj_cnt = 0;
      while (tcyc < 79) begin run_to(tcyc + 1); inj_cnt += int'(inj); end
      check("R3 no early inject", inj_cnt, 0);
      run_to(80);
      check("R3 root inject", int'(inj), 1);
      check("R4 first at root slot start", int'(first), 1);
      run_to(95);
      check("R4 first at root slot end", int'(first), 1);
      run_to(96);
      check("R4 first low after root slot", int'(first), 0);
      run_to(150); fault = 1'b1;                 // R9 latch while running
      run_to(200); flags = 4'b0101;              // R10 ignored
      inj_cnt = 0;
      while (tcyc < 335) begin run_to(tcyc + 1); inj_cnt += int'(inj); end
      check("R5 root does not reinject", inj_cnt, 0);
      check("R8 no early done", int'(done), 0);
      run_to(336);
      check("R8 done after last slot", int'(done), 1);
      check("R9 latched fault re-arms and injects", int'(inj), 1);
      check("R9 re-armed node is root again", int'(first), 1);
      run_to(337);
      check("R8 done single cycle", int'(done), 0);
      run_to(592);
      check("R8 second done", int'(done), 1);

      // ---- Scenario B: resigning detector
      do_reset(3);
      run_to(5); fault = 1'b1;
      run_to(20); flags = 4'b1000;
      run_to(25);
      check("R7 first in new root slot", int'(first), 1);
      run_to(32);
      check("R7 first low after slot 1", int'(first), 0);
      run_to(48);
      check("R7 resigned node still broadcasts", int'(inj), 1);
      check("R7 resigned node not root", int'(first), 0);
      run_to(272);
      check("R7 done relative to foreign root", int'(done), 1);

      // ---- Scenario C: idle joiner, root 15, owner wrap
      do_reset(0);
      run_to(245); flags = 4'b0010;
      run_to(250);
      check("R6 joiner sees root slot", int'(first), 1);
      run_to(256);
      check("R1 owner wraps to 0", int'(owner), 0);
      check("R5 joiner injects at own slot", int'(inj), 1);
      run_to(495);
      check("R8 no done before wrap end", int'(done), 0);
      run_to(496);
      check("R8 done for root 15", int'(done), 1);

      // ---- Scenario D: flag arrives together with own slot start
      do_reset(2);
      run_to(4); fault = 1'b1;
      run_to(32); flags = 4'b0001;
      check("R11 armed node injects despite flag", int'(inj), 1);
      run_to(288);
      check("R11 done for own root", int'(done), 1);

      // ---- random phase against the model
      void'($urandom(32'd1234));
      for (int r = 0; r < 4; r++) begin
         do_reset(int'($urandom_range(0, N - 1)));
         for (int c = 0; c < 1500; c++) begin
            @(negedge clk);
            check("R3/R5 random inj", int'(inj), int'(m_inj(tcyc)));
            check("R4 random first", int'(first), int'(m_first(tcyc)));
            check("R8/R9 random done", int'(done), int'(m_done));
            check("R1 random owner", int'(owner), own_of(tcyc));
            fault = ($urandom_range(0, 199) == 0);
            for (int p = 0; p < P; p++) flags[p] = ($urandom_range(0, 299) == 0);
         end
      end

      finished = 1'b1;
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end

   initial begin
      #(8 * 150000);
      if (!finished) begin
         n_chk++;
         n_err++;
         $display("FAIL watchdog: actual=hung expected=finished");
         $display("Result: errors=%0d of %0d checks", n_err, n_chk);
         $finish;
      end
   end
endmodule